// File: doc/BRIEF.md
# Sixteen-Channel LED PWM Output Stage

This block drives sixteen active-high LED enables from per-channel 8-bit brightness values. One shared 8-bit frame counter steps once for each one-cycle input tick and wraps from 255 to 0, so a full frame lasts 256 ticks. Each channel compares its brightness value against the counter to form a fast PWM wave. The frame rate is the same for every channel and is set by the tick rate, nominally close to 97 kHz per frame.

Each channel also has a 2-bit output-mode field. The mode picks what reaches the pin: held low, held high, the channel's own PWM wave, or that wave gated by a shared, slower group-gate input. Brightness values are written through a byte-addressed port. Channel 0 sits at address 02h and channel 15 at 11h. A written brightness is held back and applied only at the next frame boundary. Mode fields are written through a separate channel-indexed port and take effect at once.

Top module: `led_pwm_bank`

## Requirements
- R1: After synchronous reset every brightness value (pending and applied) is 00h, every mode field is 00, the frame counter is 0, and all sixteen outputs are low.
- R2: The frame counter increases by one on each clock edge where `tick` is high, wraps from 255 to 0, and holds its value when `tick` is low.
- R3: In mode 10 a channel's output is high exactly while the frame counter is strictly less than its applied brightness value.
- R4: In mode 11 a channel's output is its mode-10 PWM wave ANDed with `groupGate`.
- R5: In mode 00 a channel's output is low whatever its brightness value.
- R6: In mode 01 a channel's output is high whatever its brightness value.
- R7: Brightness 00h keeps a mode-10 output low for all 256 ticks of a frame, and FFh keeps it high for 255 of them.
- R8: A written brightness value becomes the applied value only on the edge where the counter wraps from 255 to 0. A write on that same edge waits for the following wrap.
- R9: A brightness write to address 02h+i updates channel i only. Writes to addresses below 02h or above 11h change no channel.
- R10: A mode write to channel `modeSel` changes that channel's output from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe that advances the frame counter |
| dutyWe | input | 1 | Brightness write enable |
| dutyAddr | input | 8 | Brightness register address (02h to 11h valid) |
| dutyData | input | 8 | Brightness value to write |
| modeWe | input | 1 | Mode write enable |
| modeSel | input | 4 | Channel whose mode field is written |
| modeData | input | 2 | Mode code: 00 off, 01 on, 10 PWM, 11 PWM AND group gate |
| groupGate | input | 1 | Shared slow group gate used by mode 11 |
| ledOn | output | 16 | Active-high LED enables, bit i is channel i |

## Verification
The assertions assume that `groupGate` is a level that the block only samples combinationally. They also assume that the write ports carry one transaction per cycle, with addresses and data stable from one falling edge to the next. The stimulus drives every input on the falling clock edge and holds it for a full cycle, so each rising edge sees settled values. The stimulus sometimes keeps `tick` low for stretches of cycles. It also issues writes at arbitrary counter positions, including the wrap edge, and sends writes to addresses outside 02h..11h. This covers the hold, deferral and ignore rules without leaving the assumed input protocol.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
  parameter int LED_CH    = 16;
  parameter int DUTY_W    = 8;
  parameter int ADDR_W    = 8;
  parameter int BASE_ADDR = 2;
  localparam int SEL_W    = $clog2(LED_CH);

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_ON  = 2'b01,
    MODE_PWM = 2'b10,
    MODE_GRP = 2'b11
  } ledMode_e;

  typedef struct packed {
    logic              frameWrap;
    logic [LED_CH-1:0] dutyLoad;
    logic [LED_CH-1:0] modeLoad;
    logic [DUTY_W-1:0] wrDuty;
    ledMode_e          wrMode;
  } ctrlStrobe_t;
endpackage

// File: rtl/led_pwm_ctrl.sv
module led_pwm_ctrl
  import led_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              dutyWe,
  input  logic [ADDR_W-1:0] dutyAddr,
  input  logic [DUTY_W-1:0] dutyData,
  input  logic              modeWe,
  input  logic [SEL_W-1:0]  modeSel,
  input  logic [1:0]        modeData,
  output logic [DUTY_W-1:0] frameCount,
  output ctrlStrobe_t       strobe
);
  localparam logic [DUTY_W-1:0] LAST_STEP = '1;

  // shared frame counter
  always_ff @(posedge clk) begin
    if (rst)       frameCount <= '0;
    else if (tick) frameCount <= frameCount + 1'b1;
  end

  // per-channel write decode
  for (genvar i = 0; i < LED_CH; i++) begin : g_dec
    assign strobe.dutyLoad[i] = dutyWe && (dutyAddr == ADDR_W'(BASE_ADDR + i));
    assign strobe.modeLoad[i] = modeWe && (modeSel == SEL_W'(i));
  end

  assign strobe.frameWrap = tick && (frameCount == LAST_STEP);
  assign strobe.wrDuty    = dutyData;
  assign strobe.wrMode    = ledMode_e'(modeData);
endmodule

// File: rtl/led_pwm_dp.sv
module led_pwm_dp
  import led_pwm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStrobe_t              strobe,
  input  logic [DUTY_W-1:0]        frameCount,
  input  logic                     groupGate,
  output logic [LED_CH*DUTY_W-1:0] activeFlat,
  output logic [LED_CH*2-1:0]      modeFlat,
  output logic [LED_CH-1:0]        ledOn
);
  for (genvar i = 0; i < LED_CH; i++) begin : g_ch
    logic [DUTY_W-1:0] pendDuty;
    logic [DUTY_W-1:0] liveDuty;
    ledMode_e          chMode;
    logic              pwmHigh;

    always_ff @(posedge clk) begin
      if (rst) begin
        pendDuty <= '0;
        liveDuty <= '0;
        chMode   <= MODE_OFF;
      end else begin
        if (strobe.dutyLoad[i]) pendDuty <= strobe.wrDuty;
        if (strobe.frameWrap)   liveDuty <= pendDuty;
        if (strobe.modeLoad[i]) chMode   <= strobe.wrMode;
      end
    end

    assign pwmHigh = frameCount < liveDuty;

    always_comb begin
      unique case (chMode)
        MODE_OFF: ledOn[i] = 1'b0;
        MODE_ON:  ledOn[i] = 1'b1;
        MODE_PWM: ledOn[i] = pwmHigh;
        MODE_GRP: ledOn[i] = pwmHigh & groupGate;
        default:  ledOn[i] = 1'b0;
      endcase
    end

    assign activeFlat[i*DUTY_W +: DUTY_W] = liveDuty;
    assign modeFlat[i*2 +: 2]             = chMode;
  end
endmodule

// File: rtl/led_pwm_bank.sv
module led_pwm_bank
  import led_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              dutyWe,
  input  logic [ADDR_W-1:0] dutyAddr,
  input  logic [DUTY_W-1:0] dutyData,
  input  logic              modeWe,
  input  logic [SEL_W-1:0]  modeSel,
  input  logic [1:0]        modeData,
  input  logic              groupGate,
  output logic [LED_CH-1:0] ledOn
);
  ctrlStrobe_t              strobe;
  logic [DUTY_W-1:0]        frameCount;
  logic [LED_CH*DUTY_W-1:0] activeFlat;
  logic [LED_CH*2-1:0]      modeFlat;

  led_pwm_ctrl u_ctrl (
    .clk, .rst, .tick, .dutyWe, .dutyAddr, .dutyData,
    .modeWe, .modeSel, .modeData, .frameCount, .strobe
  );

  led_pwm_dp u_dp (
    .clk, .rst, .strobe, .frameCount, .groupGate,
    .activeFlat, .modeFlat, .ledOn
  );
endmodule

// File: rtl/led_pwm_chk.sv
module led_pwm_chk
  import led_pwm_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic                     tick,
  input logic                     groupGate,
  input logic [DUTY_W-1:0]        frameCount,
  input logic [LED_CH*DUTY_W-1:0] activeFlat,
  input logic [LED_CH*2-1:0]      modeFlat,
  input logic [LED_CH-1:0]        ledOn
);
  logic lastStep;
  assign lastStep = tick && (frameCount == {DUTY_W{1'b1}});

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (frameCount == '0) && (activeFlat == '0) && (modeFlat == '0) && (ledOn == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> frameCount == DUTY_W'($past(frameCount) + 1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(frameCount));

  // R8
  duty_defer_chk: assert property (@(posedge clk) disable iff (rst)
    !lastStep |=> $stable(activeFlat));

  for (genvar i = 0; i < LED_CH; i++) begin : g_lane
    // R5
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
      (modeFlat[i*2 +: 2] == 2'b00) |-> !ledOn[i]);
    // R6
    mode_on_chk: assert property (@(posedge clk) disable iff (rst)
      (modeFlat[i*2 +: 2] == 2'b01) |-> ledOn[i]);
    // R4
    group_gate_chk: assert property (@(posedge clk) disable iff (rst)
      ((modeFlat[i*2 +: 2] == 2'b11) && !groupGate) |-> !ledOn[i]);
    // R7
    zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
      (modeFlat[i*2+1] && (activeFlat[i*DUTY_W +: DUTY_W] == '0)) |-> !ledOn[i]);
    // R3
    pwm_cmp_chk: assert property (@(posedge clk) disable iff (rst)
      (modeFlat[i*2 +: 2] == 2'b10) |-> (ledOn[i] == (frameCount < activeFlat[i*DUTY_W +: DUTY_W])));
  end
endmodule

bind led_pwm_bank led_pwm_chk u_chk (
  .clk, .rst, .tick, .groupGate, .frameCount, .activeFlat, .modeFlat, .ledOn
);

// File: tb/sim_led_pwm_bank.sv
`timescale 1ns/100ps
module sim_led_pwm_bank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       dutyWe = 1'b0;
  logic [7:0] dutyAddr = '0;
  logic [7:0] dutyData = '0;
  logic       modeWe = 1'b0;
  logic [3:0] modeSel = '0;
  logic [1:0] modeData = '0;
  logic       groupGate = 1'b0;
  logic [15:0] ledOn;

  int total = 0;
  int fails = 0;
  bit compareOn = 1'b0;

  // behavioural reference state
  int mCnt = 0;
  int mPend[16];
  int mLive[16];
  int mMode[16];

  always #2.5 clk = ~clk;

  led_pwm_bank u0 (
    .clk, .rst, .tick, .dutyWe, .dutyAddr, .dutyData,
    .modeWe, .modeSel, .modeData, .groupGate, .ledOn
  );

  function automatic bit expOut(int ch);
    case (mMode[ch])
      0: return 1'b0;
      1: return 1'b1;
      2: return mCnt < mLive[ch];
      default: return (mCnt < mLive[ch]) && groupGate;
    endcase
  endfunction

  function automatic string modeTag(int ch);
    case (mMode[ch])
      0: return "R5";
      1: return "R6";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0;
      for (int i = 0; i < 16; i++) begin mPend[i] = 0; mLive[i] = 0; mMode[i] = 0; end
    end else begin
      if (modeWe) mMode[modeSel] = modeData;
      if (tick) begin
        if (mCnt == 255) for (int i = 0; i < 16; i++) mLive[i] = mPend[i];
        mCnt = (mCnt + 1) % 256;
      end
      if (dutyWe && dutyAddr >= 8'h02 && dutyAddr <= 8'h11) mPend[dutyAddr - 2] = dutyData;
    end
  end

  always @(negedge clk) begin
    #1;
    if (compareOn) begin
      for (int i = 0; i < 16; i++) begin
        total++;
        if (ledOn[i] !== expOut(i)) begin
          fails++;
          $display("FAIL %s/R2 ch%0d cnt %0d: actual %0d expected %0d",
                   modeTag(i), i, mCnt, ledOn[i], expOut(i));
        end
      end
    end
  end

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic writeDuty(int addr, int val);
    @(negedge clk);
    dutyWe = 1'b1; dutyAddr = 8'(addr); dutyData = 8'(val);
    @(negedge clk);
    dutyWe = 1'b0;
  endtask

  task automatic writeMode(int ch, int code);
    @(negedge clk);
    modeWe = 1'b1; modeSel = 4'(ch); modeData = 2'(code);
    @(negedge clk);
    modeWe = 1'b0;
  endtask

  task automatic waitCount(int c);
    tick = 1'b1;
    do @(negedge clk); while (mCnt != c);
  endtask

  task automatic frameOnTime(output int onCnt[16]);
    for (int i = 0; i < 16; i++) onCnt[i] = 0;
    waitCount(0);
    for (int k = 0; k < 256; k++) begin
      #1;
      for (int i = 0; i < 16; i++) if (ledOn[i]) onCnt[i]++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int onCnt[16];
    logic [15:0] held;
    cyc(3);
    rst = 1'b0;
    #1;
    check("R1 outputs after reset", ledOn, 0);
    compareOn = 1'b1;

    // all channels in PWM mode, assorted duties
    for (int i = 0; i < 16; i++) writeDuty(2 + i, i * 17);
    writeDuty(2, 0);
    writeDuty(3, 255);
    for (int i = 0; i < 16; i++) writeMode(i, 2);
    frameOnTime(onCnt);
    frameOnTime(onCnt);
    check("R7 zero duty on-time", onCnt[0], 0);
    check("R7 full duty on-time", onCnt[1], 255);
    check("R3 ch9 on-time", onCnt[9], 153);

    // R9: out-of-range writes leave every channel alone
    writeDuty(8'h01, 8'hAA);
    writeDuty(8'h12, 8'hAA);
    writeDuty(8'hF0, 8'hAA);
    frameOnTime(onCnt);
    frameOnTime(onCnt);
    check("R9 ch0 unchanged", onCnt[0], 0);
    check("R9 ch15 unchanged", onCnt[15], 255);
    writeDuty(8'h11, 40);
    frameOnTime(onCnt);
    frameOnTime(onCnt);
    check("R9 ch15 addressed write", onCnt[15], 40);
    check("R9 ch14 untouched", onCnt[14], 238);

    // R8: mid-frame write waits for the wrap
    writeDuty(4, 5);
    waitCount(0);
    waitCount(10);
    dutyWe = 1'b1; dutyAddr = 8'h04; dutyData = 8'd200;
    @(negedge clk); dutyWe = 1'b0;
    waitCount(100);
    #1 check("R8 old duty still live", ledOn[2], 0);
    waitCount(100);
    #1 check("R8 new duty after wrap", ledOn[2], 1);

    // R8: write on the wrap edge is deferred one more frame
    waitCount(255);
    dutyWe = 1'b1; dutyAddr = 8'h04; dutyData = 8'd3;
    @(negedge clk); dutyWe = 1'b0;
    waitCount(50);
    #1 check("R8 wrap-edge write deferred", ledOn[2], 1);
    waitCount(50);
    #1 check("R8 deferred write applied", ledOn[2], 0);

    // R2: counter holds without tick
    waitCount(30);
    tick = 1'b0;
    #1 held = ledOn;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      check("R2 hold without tick", ledOn, held);
    end

    // sparse ticks
    for (int k = 0; k < 1200; k++) begin
      @(negedge clk); tick = ($urandom_range(0, 2) != 0);
    end

    // R4, R5, R6, R10: mixed modes with a toggling group gate
    for (int i = 0; i < 16; i++) writeMode(i, i % 4);
    writeMode(3, 1);
    #1 check("R10 mode write next cycle", ledOn[3], 1);
    writeMode(3, 0);
    #1 check("R10 mode off next cycle", ledOn[3], 0);
    check("R5 forced off", ledOn[4], 0);
    check("R6 forced on", ledOn[5], 1);
    tick = 1'b1;
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      if (k % 37 == 0) groupGate = ~groupGate;
      if (k % 300 == 0) writeDuty(2 + $urandom_range(0, 15), $urandom_range(0, 255));
    end
    groupGate = 1'b0;
    waitCount(0);
    #1 check("R4 gate low blocks mode 11", ledOn[15], 0);

    // reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1 check("R1 outputs after second reset", ledOn, 0);
    cyc(300);

    compareOn = 1'b0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule